// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by an integer N = B·P + A. A prescaler counts either P or P+1 input cycles per output tick. Two down counters, A and B, advance on every prescaler tick. While the A counter is still running, the modulus-control output stays high and the prescaler counts P+1. Once A reaches zero, the prescaler counts P for the ticks that remain before B reaches zero. When B reaches zero, the block emits a one-cycle pulse and reloads both counters. Because A picks how many prescaler periods use the longer modulus, every integer N is reachable, and the prescaler's coarse step does not cost resolution.

The P, A and B inputs are captured only when the counters reload. A change made partway through a period therefore takes effect at the next period boundary and never produces a corrupt period. Valid operation needs B > A. For any other setting the block raises a configuration-error flag and divides by (P+1)·B.

Top module: `pulse_swallow_div`

## Requirements
- R1: With B > A ≥ 1 and P in range, `div_o` pulses exactly once every B·P + A input cycles.
- R2: `div_o` is high for exactly one input cycle per period. The first pulse after reset comes in the N-th cycle after the first rising clock edge with `rst_ni` high.
- R3: In each period, `mod_o` is 1 (prescaler modulus P+1) for the first A·(P+1) cycles and 0 (modulus P) for the rest of the period.
- R4: With A = 0 and B ≥ 1, the period is B·P cycles and `mod_o` stays 0.
- R5: P, A and B are sampled only in the cycle in which `div_o` is high (or the first cycle after reset). Changes at any other time do not alter the period in progress.
- R6: If B ≤ A at a sample point, `cfg_err_o` is 1 for the whole next period, the period lasts (P+1)·B cycles, and `mod_o` is 1 throughout. B = 0 is taken as B = 1.
- R7: After the setting is corrected, `cfg_err_o` returns to 0 at the next sample point, and the division ratio is B·P + A from that period on.
- R8: P is clamped to the range 2 to 64. Values below 2 act as 2 and values above 64 act as 64.
- R9: While `rst_ni` is low, `div_o`, `mod_o` and `cfg_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock at the oscillator rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| p_i | input | 7 | Prescaler base modulus P (clamped to 2..64) |
| a_i | input | 12 | Swallow count A |
| b_i | input | 12 | Main count B |
| div_o | output | 1 | One-cycle pulse per divided period |
| mod_o | output | 1 | Modulus control: 1 = prescaler counts P+1 |
| cfg_err_o | output | 1 | Setting for the current period had B ≤ A |

## Verification
The assertions check several properties on every cycle. The output pulse is never wider than one cycle. The A remainder stays below the B remainder in valid mode. `mod_o` is low at the end of a valid period and high at the end of an error period. The captured settings never move between sample points, and the prescaler count stays within its clamp. Period lengths, the exact position of the modulus switch, the handling of mid-period changes, clamping, and recovery from an error setting cannot be seen one cycle at a time. The bench's scenarios show these by comparing every cycle against a behavioural model.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  localparam int unsigned P_W   = 7;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned P_MIN = 2;
  localparam int unsigned P_MAX = 64;
endpackage

// File: rtl/pswl_down_ctr.sv
module pswl_down_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (ld_i)                   cnt_q <= ld_val_i;
    else if (en_i && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pswl_cfg.sv
module pswl_cfg
  import pswl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic [P_W-1:0]   p_i,
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  output logic [P_W-1:0]   p_nx_o,
  output logic [CNT_W-1:0] a_nx_o,
  output logic [CNT_W-1:0] b_nx_o,
  output logic [P_W-1:0]   p_q_o,
  output logic             err_q_o
);
  logic             err_nx;
  logic [P_W-1:0]   p_q;
  logic             err_q;

  always_comb begin
    if (p_i < P_W'(P_MIN))      p_nx_o = P_W'(P_MIN);
    else if (p_i > P_W'(P_MAX)) p_nx_o = P_W'(P_MAX);
    else                        p_nx_o = p_i;
    b_nx_o = (b_i == '0) ? CNT_W'(1) : b_i;
    err_nx = (b_i <= a_i);
    // error mode: every B tick uses the long modulus
    a_nx_o = err_nx ? b_nx_o : a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q   <= P_W'(P_MIN);
      err_q <= 1'b0;
    end else if (smp_i) begin
      p_q   <= p_nx_o;
      err_q <= err_nx;
    end
  end

  assign p_q_o   = p_q;
  assign err_q_o = err_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(smp_i) |-> ($stable(p_q) && $stable(err_q))); // R5
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pswl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [6:0]       p_i,
  input  logic [11:0]      a_i,
  input  logic [11:0]      b_i,
  output logic             div_o,
  output logic             mod_o,
  output logic             cfg_err_o
);
  logic [P_W-1:0]   p_nx, p_q, p_sel, psc_len_m1, psc_cnt;
  logic [CNT_W-1:0] a_nx, b_nx, a_cnt, b_cnt;
  logic             err_q, tick, reload, a_nz_next;
  logic             psc_zero, a_zero, b_zero;

  pswl_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (reload),
    .p_i     (p_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .p_nx_o  (p_nx),
    .a_nx_o  (a_nx),
    .b_nx_o  (b_nx),
    .p_q_o   (p_q),
    .err_q_o (err_q)
  );

  assign tick   = psc_zero;
  // b_cnt is 0 only before the first load after reset
  assign reload = tick && (b_cnt <= CNT_W'(1));
  assign a_nz_next = reload ? (a_nx != '0) : (a_cnt > CNT_W'(1));
  assign p_sel  = reload ? p_nx : p_q;
  assign psc_len_m1 = p_sel - P_W'(1) + {{(P_W-1){1'b0}}, a_nz_next};

  pswl_down_ctr #(.W(P_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (tick),
    .ld_val_i (psc_len_m1),
    .en_i     (1'b1),
    .cnt_o    (psc_cnt),
    .zero_o   (psc_zero)
  );

  pswl_down_ctr #(.W(CNT_W)) u_a_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (reload),
    .ld_val_i (a_nx),
    .en_i     (tick),
    .cnt_o    (a_cnt),
    .zero_o   (a_zero)
  );

  pswl_down_ctr #(.W(CNT_W)) u_b_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (reload),
    .ld_val_i (b_nx),
    .en_i     (tick),
    .cnt_o    (b_cnt),
    .zero_o   (b_zero)
  );

  assign div_o     = tick && (b_cnt == CNT_W'(1));
  assign mod_o     = !a_zero;
  assign cfg_err_o = err_q;

  AST_PULSE_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o); // R2
  AST_A_BELOW_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_o && !b_zero) |-> (a_cnt < b_cnt)); // R1
  AST_MOD_END_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && !cfg_err_o) |-> !mod_o); // R3
  AST_ERR_MOD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && cfg_err_o) |-> mod_o); // R6
  AST_PSC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_cnt <= P_W'(P_MAX)); // R8
endmodule

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0]  p = 7'd4;
  logic [11:0] a = 12'd3;
  logic [11:0] b = 12'd5;
  logic div_w, mod_w, err_w;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_req = "R2";

  // behavioural model state
  int phase = 0, n_cur = 0, mhi_cur = 0;
  bit boot = 1'b1, err_cur = 1'b0;

  always #2.5 clk = ~clk;

  pulse_swallow_div uut (
    .clk_i(clk), .rst_ni(rst_n), .p_i(p), .a_i(a), .b_i(b),
    .div_o(div_w), .mod_o(mod_w), .cfg_err_o(err_w)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d", req, what, cyc, got, exp);
    end
  endtask

  task automatic load_model();
    int pe, be, ae;
    bit e;
    pe = (p < 2) ? 2 : ((p > 64) ? 64 : int'(p));
    be = (b == 0) ? 1 : int'(b);
    e  = (b <= a);
    ae = e ? be : int'(a);
    n_cur   = e ? (pe + 1) * be : be * pe + int'(a);
    mhi_cur = ae * (pe + 1);
    err_cur = e;
    phase = 1;
    boot = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9", "div", div_w, 0);
      chk("R9", "mod", mod_w, 0);
      chk("R9", "err", err_w, 0);
      boot = 1'b1;
    end else if (boot) begin
      chk(cur_req, "div", div_w, 0);
      chk(cur_req, "mod", mod_w, 0);
      load_model();
    end else begin
      chk(cur_req, "div", div_w, (phase == n_cur) ? 1 : 0);
      chk(cur_req, "mod", mod_w, (phase <= mhi_cur) ? 1 : 0);
      chk(cur_req, "err", err_w, err_cur ? 1 : 0);
      if (phase == n_cur) load_model();
      else phase++;
    end
  end

  task automatic set_cfg(input int pv, input int av, input int bv);
    @(posedge clk); #1;
    p = 7'(pv); a = 12'(av); b = 12'(bv);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    wait_cyc(4); #1;
    rst_n = 1'b1;
    cur_req = "R2";            // first pulse at N=23
    wait_cyc(30);
    cur_req = "R1";
    wait_cyc(70);
    set_cfg(7, 4, 9);  cur_req = "R3";  wait_cyc(200);
    set_cfg(3, 0, 6);  cur_req = "R4";  wait_cyc(80);
    // mid-period change: model samples only at period end
    set_cfg(5, 2, 7);  cur_req = "R5";  wait_cyc(13);
    set_cfg(2, 1, 3);  wait_cyc(9);
    set_cfg(6, 3, 4);  wait_cyc(90);
    set_cfg(3, 5, 3);  cur_req = "R6";  wait_cyc(80);
    set_cfg(4, 0, 0);  wait_cyc(40);
    set_cfg(4, 2, 5);  cur_req = "R7";  wait_cyc(90);
    set_cfg(0, 1, 3);  cur_req = "R8";  wait_cyc(40);
    set_cfg(100, 1, 2); wait_cyc(400);
    set_cfg(64, 2, 3); wait_cyc(400);
    // reset mid-period
    @(posedge clk); #1; rst_n = 1'b0;
    wait_cyc(3); #1; rst_n = 1'b1;
    cur_req = "R2";
    wait_cyc(500);
    finish_run();
  end
endmodule